// File: doc/BRIEF.md
# Receive Ring Buffer Writer

This block sits between a receive frame stream and memory. It stores each incoming Ethernet frame in a circular receive buffer and shares a set of pointers with the host. Each stored packet starts with a four-byte header: a little-endian status word and a little-endian byte count. The frame bytes follow the header, including the trailing CRC. The next packet starts at the following dword boundary. The output is a plain registered byte write port: address, data and write enable.

The host sees four things. It sets the buffer base address and moves a read-pointer register as it consumes packets. It reads back the current write offset and a buffer-empty flag. The read-pointer register is biased: its value is the true read offset minus sixteen, counted modulo 2^16. Two settings control storage. A two-bit selector picks one of four ring sizes. A linear-spill mode lets a frame that runs off the end of the ring continue past the end in memory, instead of folding back to offset zero.

The header's byte count is only known when the frame ends. So payload bytes are written as they arrive, starting four bytes into the slot. The four header bytes are written in the four cycles after the last byte. The write offset advances only after that. A frame that would run into unread data is abandoned, and its slot is reused by the next frame.

Top module: `rx_ring_writer`

## Requirements
- R1: After reset, the write offset is 0, the read-pointer register reads 0xFFF0, the empty flag is 1, the missed count is 0, and no memory write is issued.
- R2: The ring holds 2^(MIN_LOG2+ring_sel) bytes. MIN_LOG2 = 13 gives 8, 16, 32 and 64 KB for selector values 0 to 3. The write offset always stays below the ring size.
- R3: For a packet stored at slot offset S, the four header bytes are written as follows:
  - S holds status byte 0. Bit 0 is the frame's good flag and bits 7:1 are 0.
  - S+1 holds status byte 1, which is 0.
  - S+2 holds the low byte of the frame length.
  - S+3 holds the high byte of the frame length.
  - The length counts every frame byte, including the CRC.
- R4: Frame byte i (counting from 0) is written at slot offset S+4+i, in arrival order.
- R5: After an accepted frame of length L, the write offset becomes (S + ((L+4+3) & ~3)) mod ring size. It is always a multiple of 4.
- R6: With linear spill off, every frame byte offset is reduced modulo the ring size, so a frame crossing the ring end continues at offset 0.
- R7: With linear spill on, frame bytes are written at S+4+i without reduction, running past the ring end.
- R8: The host writes the read-pointer register and reads the written value back. The true read offset is ((register + 16) mod 2^16) mod ring size.
- R9: The empty flag is 1 exactly when the true read offset equals the write offset, lagging these values by one cycle.
- R10: A frame is dropped when L + 8 exceeds the free space. Free space is (read offset - S) mod ring size, or the whole ring when that result is 0. On a drop, the missed count increases by exactly 1 and the write offset does not change.
- R11: A frame whose start arrives while receive enable is 0 causes no memory write. The write offset and the missed count are unchanged.
- R12: Every write goes to buf_base + offset. It appears on the memory port one cycle after the byte or header step that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receive enable, sampled at frame start |
| spill_en | input | 1 | Linear spill past the ring end |
| ring_sel | input | 2 | Ring size selector |
| buf_base | input | ADDR_W | Memory address of ring offset 0 |
| host_rp_we | input | 1 | Host write strobe for the read pointer |
| host_rp_wdata | input | 16 | Biased read pointer value from the host |
| in_valid | input | 1 | Frame byte valid |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_good | input | 1 | Frame received intact, valid with in_eof |
| in_data | input | 8 | Frame byte |
| mem_addr | output | ADDR_W | Memory write address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| host_rp | output | 16 | Biased read pointer register |
| wr_offset | output | OFF_W | Current write offset in the ring |
| buf_empty | output | 1 | Ring holds no unread packet |
| missed_count | output | CNT_W | Frames dropped for lack of room |

## Verification
The hardest situations to reach are two boundaries: the ring end crossed in the middle of a frame, and a frame that is exactly one byte too long for the space left. The bench works on a small ring, where every slot moves quickly. For each of the four ring sizes and both spill settings, it sweeps frame lengths upward while consuming each packet. The write offset therefore walks through every dword slot and crosses the ring end at many different points inside a frame. Separately, the bench fills the ring without consuming and offers frames of length ring-8 and ring-7 on an empty ring. Both cases hit the drop limit exactly.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RECV = 2'd1,
    ST_DROP = 2'd2,
    ST_HDR  = 2'd3
  } rx_state_e;

  // bytes in the per-packet header
  localparam int HDR_BYTES = 4;
  // bias between the host pointer register and the true read offset
  localparam int RP_BIAS = 16;
endpackage

// File: rtl/rx_ring_ptrs.sv
module rx_ring_ptrs #(
  parameter int MIN_LOG2 = 13,
  parameter int OFF_W    = MIN_LOG2 + 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       ring_sel,
  input  logic             host_rp_we,
  input  logic [15:0]      host_rp_wdata,
  input  logic [OFF_W-1:0] wr_off,
  output logic [15:0]      host_rp,
  output logic [OFF_W-1:0] ring_mask,
  output logic [OFF_W:0]   space,
  output logic             buf_empty
);
  import rx_ring_pkg::*;

  localparam logic [15:0] RP_RESET = 16'(65536 - RP_BIAS);

  logic [OFF_W-1:0] ring_bytes;
  logic [OFF_W-1:0] rd_off;
  logic [OFF_W-1:0] gap;
  logic [15:0]      rd_true;

  assign ring_bytes = OFF_W'(1) << (MIN_LOG2 + int'(ring_sel));
  assign ring_mask  = ring_bytes - OFF_W'(1);
  assign rd_true    = host_rp + 16'(RP_BIAS);
  assign rd_off     = OFF_W'(rd_true) & ring_mask;
  assign gap        = (rd_off - wr_off) & ring_mask;
  // a zero gap means the ring is empty, so the whole ring is free
  assign space      = (gap == '0) ? {1'b0, ring_bytes} : {1'b0, gap};

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rp   <= RP_RESET;
      buf_empty <= 1'b1;
    end else begin
      if (host_rp_we) host_rp <= host_rp_wdata;
      buf_empty <= (rd_off == wr_off);
    end
  end
endmodule

// File: rtl/rx_ring_seq.sv
module rx_ring_seq #(
  parameter int MIN_LOG2 = 13,
  parameter int OFF_W    = MIN_LOG2 + 5,
  parameter int CNT_W    = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_en,
  input  logic             spill_en,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic             in_good,
  input  logic [7:0]       in_data,
  input  logic [OFF_W-1:0] ring_mask,
  input  logic [OFF_W:0]   space,
  output logic             req_we,
  output logic [OFF_W-1:0] req_off,
  output logic [7:0]       req_data,
  output logic [OFF_W-1:0] wr_off,
  output logic [CNT_W-1:0] missed
);
  import rx_ring_pkg::*;

  // a slot must leave one dword before the read offset after alignment
  localparam logic [OFF_W:0] MARGIN = (OFF_W+1)'(1 + 2 * HDR_BYTES);

  rx_state_e        st_q;
  logic [OFF_W-1:0] cnt_q;
  logic [1:0]       hc_q;
  logic             good_q;
  logic [OFF_W-1:0] wr_q;
  logic [CNT_W-1:0] miss_q;

  logic             starting;
  logic             accept;
  logic             fits;
  logic             store;
  logic [OFF_W-1:0] base_cnt;
  logic [OFF_W:0]   need;
  logic [OFF_W-1:0] byte_lin;
  logic [OFF_W-1:0] byte_off;
  logic [OFF_W-1:0] hdr_off;
  logic [OFF_W-1:0] aligned;
  logic [OFF_W-1:0] next_w;
  logic [15:0]      len16;
  logic [7:0]       hdr_byte;

  assign starting = in_valid && in_sof && (st_q == ST_IDLE);
  assign accept   = (starting && rx_en) || (in_valid && (st_q == ST_RECV));
  assign base_cnt = (st_q == ST_IDLE) ? '0 : cnt_q;
  assign need     = {1'b0, base_cnt} + MARGIN;
  assign fits     = (need <= space);
  assign store    = accept && fits;

  assign byte_lin = wr_q + OFF_W'(HDR_BYTES) + base_cnt;
  assign byte_off = spill_en ? byte_lin : (byte_lin & ring_mask);
  assign hdr_off  = wr_q + OFF_W'(hc_q);
  assign aligned  = (cnt_q + OFF_W'(HDR_BYTES + 3)) & ~OFF_W'(3);
  assign next_w   = (wr_q + aligned) & ring_mask;
  assign len16    = 16'(cnt_q);

  always_comb begin
    case (hc_q)
      2'd0:    hdr_byte = {7'd0, good_q};
      2'd1:    hdr_byte = 8'd0;
      2'd2:    hdr_byte = len16[7:0];
      default: hdr_byte = len16[15:8];
    endcase
  end

  always_comb begin
    if (st_q == ST_HDR) begin
      req_we   = 1'b1;
      req_off  = hdr_off;
      req_data = hdr_byte;
    end else begin
      req_we   = store;
      req_off  = byte_off;
      req_data = in_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      hc_q   <= 2'd0;
      good_q <= 1'b0;
      wr_q   <= '0;
      miss_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE, ST_RECV: begin
          if (starting && !rx_en) begin
            st_q <= in_eof ? ST_IDLE : ST_DROP;
          end else if (accept && !fits) begin
            miss_q <= miss_q + CNT_W'(1);
            st_q   <= in_eof ? ST_IDLE : ST_DROP;
          end else if (store) begin
            cnt_q <= base_cnt + OFF_W'(1);
            if (in_eof) begin
              st_q   <= ST_HDR;
              good_q <= in_good;
              hc_q   <= 2'd0;
            end else begin
              st_q <= ST_RECV;
            end
          end
        end
        ST_DROP: begin
          if (in_valid && in_eof) st_q <= ST_IDLE;
        end
        default: begin
          hc_q <= hc_q + 2'd1;
          if (hc_q == 2'd3) begin
            wr_q <= next_w;
            st_q <= ST_IDLE;
          end
        end
      endcase
    end
  end

  assign wr_off = wr_q;
  assign missed = miss_q;
endmodule

// File: rtl/rx_ring_wport.sv
module rx_ring_wport #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_we,
  input  logic [OFF_W-1:0]  req_off,
  input  logic [7:0]        req_data,
  input  logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              mem_we
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= 8'd0;
    end else begin
      mem_we    <= req_we;
      mem_addr  <= base + ADDR_W'(req_off);
      mem_wdata <= req_data;
    end
  end
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer #(
  parameter int MIN_LOG2 = 13,
  parameter int ADDR_W   = 32,
  parameter int CNT_W    = 16,
  localparam int OFF_W   = MIN_LOG2 + 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_en,
  input  logic              spill_en,
  input  logic [1:0]        ring_sel,
  input  logic [ADDR_W-1:0] buf_base,
  input  logic              host_rp_we,
  input  logic [15:0]       host_rp_wdata,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic              in_good,
  input  logic [7:0]        in_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              mem_we,
  output logic [15:0]       host_rp,
  output logic [OFF_W-1:0]  wr_offset,
  output logic              buf_empty,
  output logic [CNT_W-1:0]  missed_count
);
  logic [OFF_W-1:0] ring_mask;
  logic [OFF_W:0]   space;
  logic             req_we;
  logic [OFF_W-1:0] req_off;
  logic [7:0]       req_data;

  rx_ring_ptrs #(.MIN_LOG2(MIN_LOG2), .OFF_W(OFF_W)) u_ptrs (
    .clk(clk), .rst(rst), .ring_sel(ring_sel),
    .host_rp_we(host_rp_we), .host_rp_wdata(host_rp_wdata),
    .wr_off(wr_offset), .host_rp(host_rp), .ring_mask(ring_mask),
    .space(space), .buf_empty(buf_empty)
  );

  rx_ring_seq #(.MIN_LOG2(MIN_LOG2), .OFF_W(OFF_W), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .rx_en(rx_en), .spill_en(spill_en),
    .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
    .in_good(in_good), .in_data(in_data),
    .ring_mask(ring_mask), .space(space),
    .req_we(req_we), .req_off(req_off), .req_data(req_data),
    .wr_off(wr_offset), .missed(missed_count)
  );

  rx_ring_wport #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_wport (
    .clk(clk), .rst(rst), .req_we(req_we), .req_off(req_off),
    .req_data(req_data), .base(buf_base),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we)
  );
endmodule

// File: rtl/rx_ring_writer_chk.sv
module rx_ring_writer_chk #(
  parameter int MIN_LOG2 = 13,
  parameter int OFF_W    = MIN_LOG2 + 5,
  parameter int CNT_W    = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       ring_sel,
  input logic [15:0]      host_rp,
  input logic [OFF_W-1:0] wr_offset,
  input logic             buf_empty,
  input logic             mem_we,
  input logic [CNT_W-1:0] missed_count
);
  logic [OFF_W-1:0] ring_bytes;
  logic [OFF_W-1:0] rd_seen;

  assign ring_bytes = OFF_W'(1) << (MIN_LOG2 + int'(ring_sel));
  assign rd_seen    = OFF_W'(host_rp + 16'd16) & (ring_bytes - OFF_W'(1));

  // R2: write offset stays inside the ring
  a_r2_offset_in_ring: assert property (@(posedge clk) disable iff (rst)
    wr_offset < ring_bytes);

  // R5: slots start on dword boundaries
  a_r5_offset_aligned: assert property (@(posedge clk) disable iff (rst)
    wr_offset[1:0] == 2'b00);

  // R5: the offset moves only together with the last header write
  a_r5_advance_with_header: assert property (@(posedge clk) disable iff (rst)
    (wr_offset != $past(wr_offset)) |-> mem_we);

  // R10: the missed count only ever steps by one
  a_r10_missed_step: assert property (@(posedge clk) disable iff (rst)
    (missed_count != $past(missed_count)) |-> (missed_count == $past(missed_count) + CNT_W'(1)));

  // R9: empty flag follows the pointer comparison one cycle later
  a_r9_empty_flag: assert property (@(posedge clk) disable iff (rst)
    buf_empty == $past(rd_seen == wr_offset));
endmodule

bind rx_ring_writer rx_ring_writer_chk #(.MIN_LOG2(MIN_LOG2), .OFF_W(OFF_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .ring_sel(ring_sel), .host_rp(host_rp),
  .wr_offset(wr_offset), .buf_empty(buf_empty), .mem_we(mem_we),
  .missed_count(missed_count)
);

// File: tb/test_rx_ring_writer.sv
`timescale 1ns/1ps
module test_rx_ring_writer;
  localparam int MIN_LOG2 = 6;
  localparam int ADDR_W   = 16;
  localparam int CNT_W    = 8;
  localparam int OFF_W    = MIN_LOG2 + 5;
  localparam int MEM_SZ   = 2048;
  localparam logic [ADDR_W-1:0] BASE = 16'h0400;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_en = 1'b1;
  logic spill_en = 1'b0;
  logic [1:0] ring_sel = 2'd0;
  logic host_rp_we = 1'b0;
  logic [15:0] host_rp_wdata = 16'd0;
  logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0, in_good = 1'b0;
  logic [7:0] in_data = 8'd0;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0] mem_wdata;
  logic mem_we;
  logic [15:0] host_rp;
  logic [OFF_W-1:0] wr_offset;
  logic buf_empty;
  logic [CNT_W-1:0] missed_count;

  rx_ring_writer #(.MIN_LOG2(MIN_LOG2), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_rx_ring_writer (
    .clk(clk), .rst(rst), .rx_en(rx_en), .spill_en(spill_en), .ring_sel(ring_sel),
    .buf_base(BASE), .host_rp_we(host_rp_we), .host_rp_wdata(host_rp_wdata),
    .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_good(in_good),
    .in_data(in_data), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .host_rp(host_rp), .wr_offset(wr_offset), .buf_empty(buf_empty),
    .missed_count(missed_count)
  );

  always #5 clk = ~clk;

  logic [7:0] mem [0:MEM_SZ-1];
  int wr_count = 0;
  int stray = 0;
  int n_checks = 0;
  int n_fail = 0;

  always @(posedge clk) begin
    if (mem_we) begin
      wr_count <= wr_count + 1;
      if (mem_addr >= BASE && int'(mem_addr - BASE) < MEM_SZ)
        mem[int'(mem_addr - BASE)] <= mem_wdata;
      else
        stray <= stray + 1;
    end
  end

  int mW, mCapr, mMissed, ring;
  bit mSpill;

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'((seed * 31 + i * 7 + 1) & 255);
  endfunction

  task automatic do_reset(input int sel, input bit spill);
    @(negedge clk);
    rst = 1'b1;
    ring_sel = 2'(sel);
    spill_en = spill;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    mW = 0; mCapr = 16'hFFF0; mMissed = 0; mSpill = spill;
    ring = 1 << (MIN_LOG2 + sel);
  endtask

  task automatic send(input int len, input bit good, input int seed);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_sof = (i == 0);
      in_eof = (i == len - 1);
      in_good = good;
      in_data = pat(seed, i);
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_good = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic frame(input int len, input bit good, input int seed);
    int rd, gap, space, s, o;
    rd = ((mCapr + 16) & 16'hFFFF) & (ring - 1);
    gap = (rd - mW) & (ring - 1);
    space = (gap == 0) ? ring : gap;
    s = mW;
    send(len, good, seed);
    if (len + 8 > space) begin
      mMissed++;
      chk("R10 missed count", int'(missed_count), mMissed & 255);
      chk("R10 offset held", int'(wr_offset), mW);
    end else begin
      chk("R3 status byte 0", int'(mem[s]), int'(good));
      chk("R3 status byte 1", int'(mem[s+1]), 0);
      chk("R3 length low", int'(mem[s+2]), len & 255);
      chk("R3 length high", int'(mem[s+3]), len >> 8);
      for (int i = 0; i < len; i++) begin
        o = mSpill ? (s + 4 + i) : ((s + 4 + i) % ring);
        if (mSpill) chk("R7 R4 spill byte", int'(mem[o]), int'(pat(seed, i)));
        else        chk("R6 R4 ring byte", int'(mem[o]), int'(pat(seed, i)));
      end
      mW = (s + ((len + 7) & ~3)) % ring;
      chk("R5 next offset", int'(wr_offset), mW);
      chk("R9 not empty", int'(buf_empty), 0);
    end
  endtask

  task automatic consume();
    mCapr = (mW - 16) & 16'hFFFF;
    @(negedge clk);
    host_rp_we = 1'b1;
    host_rp_wdata = 16'(mCapr);
    @(negedge clk);
    host_rp_we = 1'b0;
    repeat (2) @(negedge clk);
    chk("R8 pointer readback", int'(host_rp), mCapr);
    chk("R9 empty after consume", int'(buf_empty), 1);
  endtask

  initial begin
    #1_500_000;
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    int c0;
    do_reset(0, 1'b0);
    // R1 reset state
    chk("R1 offset", int'(wr_offset), 0);
    chk("R1 pointer", int'(host_rp), 16'hFFF0);
    chk("R1 empty", int'(buf_empty), 1);
    chk("R1 missed", int'(missed_count), 0);
    chk("R1 no write", int'(mem_we), 0);

    // sweep: every ring size, both end modes, many lengths
    for (int sp = 0; sp < 2; sp++) begin
      for (int sel = 0; sel < 4; sel++) begin
        do_reset(sel, sp[0]);
        for (int len = 1; len <= 40; len++) begin
          frame(len, (len % 5) != 0, len + sel * 50);
          consume();
        end
        // R2 size boundary on an empty ring
        do_reset(sel, sp[0]);
        frame(ring - 7, 1'b1, 3);
        chk("R2 one too long dropped", int'(missed_count), 1);
        frame(ring - 8, 1'b1, 4);
        chk("R2 largest fits", int'(wr_offset), ring - 4);
        consume();
      end
    end

    // fill without consuming: R10 drops
    do_reset(0, 1'b0);
    for (int k = 0; k < 7; k++) frame(8, 1'b1, 90 + k);
    chk("R10 two frames missed", int'(missed_count), 2);
    consume();

    // R11 receive disabled
    @(negedge clk);
    rx_en = 1'b0;
    c0 = wr_count;
    send(20, 1'b1, 7);
    chk("R11 no writes", wr_count, c0);
    chk("R11 offset held", int'(wr_offset), mW);
    chk("R11 missed held", int'(missed_count), mMissed);
    chk("R11 still empty", int'(buf_empty), 1);
    rx_en = 1'b1;
    frame(20, 1'b1, 8);

    // R8 bias: writing the unbiased value does not empty the ring
    @(negedge clk);
    host_rp_we = 1'b1;
    host_rp_wdata = 16'(mW);
    @(negedge clk);
    host_rp_we = 1'b0;
    repeat (2) @(negedge clk);
    chk("R8 unbiased value leaves data", int'(buf_empty), 0);
    mCapr = mW;
    consume();

    chk("R12 all writes inside buffer", stray, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule